// File: doc/BRIEF.md
# Bidirectional Port Loopback Controller

This block manages one shared bidirectional data port that sits between two FIFOs. The inbound FIFO takes words from the port. The outbound FIFO supplies words to the port. In normal operation a direction input picks the transfer. With direction high, the port writes into the inbound FIFO. With direction low, the port reads from the outbound FIFO, and the block drives the port through an output-enable.

When the active-low loop input is asserted, the block moves words from the outbound FIFO into the inbound FIFO. With direction low, those words also appear on the port. With direction high, they stay internal.

The controller produces four things: the inbound write strobe, the outbound read strobe, the inbound write-data select, and the port output enable. It also holds a registered port output word. Neither FIFO's storage is part of the block. The outbound FIFO is assumed to show its head word on `ob_rdata` and to pop that word on a clock edge where `ob_rd` is high.

Top module: `plc_loopback_ctrl`

## Requirements
- R1: With `loop_n` high and `dir` high, `ib_wr` equals `!cs_n && en && !ib_full`, `ib_wdata` equals `port_din`, and `ob_rd` stays low.
- R2: With `loop_n` high and `dir` low, `ob_rd` equals `!cs_n && en && !ob_empty`, and `ib_wr` stays low.
- R3: When `cs_n` is high or `en` is low, neither `ob_rd` nor `ib_wr` is asserted, whatever the other inputs are.
- R4: With `loop_n` low and `dir` high, `ob_rd` and `ib_wr` are both high exactly when `!cs_n && en && !ib_full && !ob_empty`; otherwise both are low. In this case `ib_wdata` equals `ob_rdata`.
- R5: With `loop_n` low and `dir` low, `ob_rd` equals `!cs_n && en && !ob_empty`, `ib_wr` equals `ob_rd && !ib_full`, and `ib_wdata` equals `ob_rdata`. A full inbound FIFO therefore sends outbound words to the port only.
- R6: After each rising edge where `ob_rd` is high and `dir` is low, `port_dout` holds the `ob_rdata` value present at that edge. Reset sets `port_dout` to zero.
- R7: `port_oe` equals `!cs_n && !dir`.
- R8: `ob_rd` is never high while `ob_empty` is high, and `ib_wr` is never high while `ib_full` is high.
- R9: `port_dout` keeps its value across every edge without a port-visible read. This includes hidden loopback transfers made with `dir` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Transfer enable |
| dir | input | 1 | 1: port writes inbound, 0: port reads outbound |
| loop_n | input | 1 | Active-low loopback select |
| port_din | input | DATA_W | Word arriving from the port pads |
| port_dout | output | DATA_W | Registered word presented to the port pads |
| port_oe | output | 1 | Port pad output enable |
| ob_rdata | input | DATA_W | Head word of the outbound FIFO |
| ob_empty | input | 1 | Outbound FIFO empty |
| ob_rd | output | 1 | Outbound FIFO read strobe |
| ib_full | input | 1 | Inbound FIFO full |
| ib_wr | output | 1 | Inbound FIFO write strobe |
| ib_wdata | output | DATA_W | Word written into the inbound FIFO |

## Verification
The bench builds the block with `DATA_W` set to 8. At that width every data value it drives can be written as a short arithmetic expression of the sweep index.

It sweeps all 64 combinations of `cs_n`, `en`, `dir`, `loop_n`, `ob_empty` and `ib_full`. For each combination it checks the strobes, the write-data select and the output enable against the requirement formulas. It also checks the port register across the following edge.

Two further sequences run against small FIFO models in the bench. In the first, a five-word outbound queue drains into a three-deep inbound queue in shown loopback, which exercises the inbound-full case. In the second, a hidden loopback transfer must leave the port word untouched.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [1:0] {
        MODE_PORT_WR     = 2'b00,
        MODE_PORT_RD     = 2'b01,
        MODE_LOOP_HIDDEN = 2'b10,
        MODE_LOOP_SHOWN  = 2'b11
    } plc_mode_e;

    function automatic plc_mode_e plc_decode(input logic loop_n, input logic dir);
        plc_mode_e m;
        case ({loop_n, dir})
            2'b11:   m = MODE_PORT_WR;
            2'b10:   m = MODE_PORT_RD;
            2'b01:   m = MODE_LOOP_HIDDEN;
            default: m = MODE_LOOP_SHOWN;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/plc_strobe_dec.sv
module plc_strobe_dec
    import plc_pkg::*;
(
    input  logic      sel,
    input  plc_mode_e mode,
    input  logic      ob_empty,
    input  logic      ib_full,
    output logic      ob_rd,
    output logic      ib_wr
);

    logic ob_ok;
    logic ib_ok;

    assign ob_ok = sel && !ob_empty;
    assign ib_ok = sel && !ib_full;

    always_comb begin
        ob_rd = 1'b0;
        ib_wr = 1'b0;
        case (mode)
            MODE_PORT_WR: begin
                ib_wr = ib_ok;
            end
            MODE_PORT_RD: begin
                ob_rd = ob_ok;
            end
            MODE_LOOP_HIDDEN: begin
                // a hidden word has nowhere to go except inward
                ob_rd = ob_ok && ib_ok;
                ib_wr = ob_ok && ib_ok;
            end
            default: begin
                // shown loop: port always takes the word, inbound only if room
                ob_rd = ob_ok;
                ib_wr = ob_ok && !ib_full;
            end
        endcase
    end

endmodule

// File: rtl/plc_wdata_mux.sv
module plc_wdata_mux #(
    parameter int DATA_W = 36
) (
    input  logic              loop_sel,
    input  logic [DATA_W-1:0] port_din,
    input  logic [DATA_W-1:0] ob_rdata,
    output logic [DATA_W-1:0] ib_wdata
);

    assign ib_wdata = loop_sel ? ob_rdata : port_din;

endmodule

// File: rtl/plc_loopback_ctrl.sv
module plc_loopback_ctrl
    import plc_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              en,
    input  logic              dir,
    input  logic              loop_n,
    input  logic [DATA_W-1:0] port_din,
    output logic [DATA_W-1:0] port_dout,
    output logic              port_oe,
    input  logic [DATA_W-1:0] ob_rdata,
    input  logic              ob_empty,
    output logic              ob_rd,
    input  logic              ib_full,
    output logic              ib_wr,
    output logic [DATA_W-1:0] ib_wdata
);

    localparam logic [DATA_W-1:0] DOUT_RST = '0;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } plc_state_t;

    plc_state_t st_d, st_q;
    plc_mode_e  mode;
    logic       sel;
    logic       shown_rd;

    assign sel  = !cs_n && en;
    assign mode = plc_decode(loop_n, dir);

    plc_strobe_dec u_dec (
        .sel      (sel),
        .mode     (mode),
        .ob_empty (ob_empty),
        .ib_full  (ib_full),
        .ob_rd    (ob_rd),
        .ib_wr    (ib_wr)
    );

    plc_wdata_mux #(.DATA_W(DATA_W)) u_mux (
        .loop_sel (!loop_n),
        .port_din (port_din),
        .ob_rdata (ob_rdata),
        .ib_wdata (ib_wdata)
    );

    assign shown_rd = ob_rd && !dir;

    always_comb begin
        st_d = st_q;
        if (shown_rd) begin
            st_d.dout = ob_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dout <= DOUT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_dout = st_q.dout;
    assign port_oe   = !cs_n && !dir;

endmodule

// File: rtl/plc_loopback_chk.sv
module plc_loopback_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              en,
    input logic              dir,
    input logic              loop_n,
    input logic              ob_empty,
    input logic              ib_full,
    input logic [DATA_W-1:0] ob_rdata,
    input logic              ob_rd,
    input logic              ib_wr,
    input logic [DATA_W-1:0] port_dout,
    input logic              port_oe
);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_empty |-> !ob_rd);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_full |-> !ib_wr);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !en) |-> (!ob_rd && !ib_wr));

    // R4
    hidden_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_n && dir) |-> (ob_rd == ib_wr));

    // R5
    loop_write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_n && ib_wr) |-> ob_rd);

    // R6
    dout_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_rd && !dir) |=> (port_dout == $past(ob_rdata)));

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ob_rd && !dir) |=> $stable(port_dout));

    // R7
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_oe |-> (!dir && !cs_n));

endmodule

bind plc_loopback_ctrl plc_loopback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .en        (en),
    .dir       (dir),
    .loop_n    (loop_n),
    .ob_empty  (ob_empty),
    .ib_full   (ib_full),
    .ob_rdata  (ob_rdata),
    .ob_rd     (ob_rd),
    .ib_wr     (ib_wr),
    .port_dout (port_dout),
    .port_oe   (port_oe)
);

// File: tb/plc_loopback_ctrl_tb.sv
module plc_loopback_ctrl_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, en = 1'b0, dir = 1'b0, loop_n = 1'b1;
    logic [W-1:0] port_din = '0;
    logic [W-1:0] port_dout;
    logic         port_oe;
    logic [W-1:0] sw_rdata = '0;
    logic         sw_empty = 1'b1, sw_full = 1'b0;
    logic         ob_rd, ib_wr;
    logic [W-1:0] ib_wdata;
    logic         use_model = 1'b0;

    // small FIFO models
    logic [W-1:0] ob_mem [8];
    logic [W-1:0] ib_mem [8];
    int           ob_head = 0, ob_cnt = 0, ib_cnt = 0;
    int           ib_cap = 3;

    wire [W-1:0] ob_rdata = use_model ? ob_mem[ob_head[2:0]] : sw_rdata;
    wire         ob_empty = use_model ? (ob_cnt == 0) : sw_empty;
    wire         ib_full  = use_model ? (ib_cnt >= ib_cap) : sw_full;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    plc_loopback_ctrl #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .dir(dir), .loop_n(loop_n),
        .port_din(port_din), .port_dout(port_dout), .port_oe(port_oe),
        .ob_rdata(ob_rdata), .ob_empty(ob_empty), .ob_rd(ob_rd),
        .ib_full(ib_full), .ib_wr(ib_wr), .ib_wdata(ib_wdata)
    );

    always @(posedge clk) begin
        if (use_model) begin
            if (ob_rd) begin
                ob_head <= ob_head + 1;
                ob_cnt  <= ob_cnt - 1;
            end
            if (ib_wr) begin
                ib_mem[ib_cnt[2:0]] <= ib_wdata;
                ib_cnt <= ib_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [W-1:0] exp_dout;
        repeat (3) @(posedge clk);
        #1 chk(port_dout == 0, "R6 reset", port_dout, 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_dout = '0;

        // exhaustive sweep of control and status combinations
        for (int i = 0; i < 64; i++) begin
            bit s, rd_e, wr_e, oe_e;
            logic [W-1:0] wd_e;
            @(negedge clk);
            {cs_n, en, dir, loop_n, sw_empty, sw_full} = 6'(i);
            sw_rdata = W'(i * 3 + 1);
            port_din = W'(i * 5 + 2);
            s = !cs_n && en;
            if (loop_n && dir) begin            // R1
                wr_e = s && !sw_full; rd_e = 1'b0; wd_e = port_din;
            end else if (loop_n) begin          // R2
                rd_e = s && !sw_empty; wr_e = 1'b0; wd_e = port_din;
            end else if (dir) begin             // R4
                rd_e = s && !sw_full && !sw_empty; wr_e = rd_e; wd_e = sw_rdata;
            end else begin                      // R5
                rd_e = s && !sw_empty; wr_e = rd_e && !sw_full; wd_e = sw_rdata;
            end
            oe_e = !cs_n && !dir;               // R7
            #1;
            chk(ob_rd == rd_e, "R2/R4/R5 ob_rd", ob_rd, rd_e);
            chk(ib_wr == wr_e, "R1/R4/R5 ib_wr", ib_wr, wr_e);
            if (wr_e) chk(ib_wdata == wd_e, "R1/R4/R5 ib_wdata", ib_wdata, wd_e);
            chk(port_oe == oe_e, "R7 port_oe", port_oe, oe_e);
            if (!s) chk(!ob_rd && !ib_wr, "R3 idle", {ob_rd, ib_wr}, 0);
            chk(!(ob_rd && sw_empty) && !(ib_wr && sw_full), "R8 guard",
                {ob_rd, ib_wr}, 0);
            if (rd_e && !dir) exp_dout = sw_rdata;
            @(posedge clk);
            #1 chk(port_dout == exp_dout, "R6/R9 port_dout", port_dout, exp_dout);
        end

        // shown loopback: 5 outbound words into a 3-deep inbound queue
        @(negedge clk);
        cs_n = 1'b1; en = 1'b0;
        for (int k = 0; k < 5; k++) ob_mem[k] = W'(8'hA0 + k);
        ob_head = 0; ob_cnt = 5; ib_cnt = 0; ib_cap = 3;
        use_model = 1'b1;
        loop_n = 1'b0; dir = 1'b0;
        @(negedge clk);
        cs_n = 1'b0; en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #1 chk(port_dout == W'(8'hA0 + k), "R5/R6 shown word", port_dout, 8'hA0 + k);
        end
        @(negedge clk);
        chk(ob_cnt == 0, "R5 outbound drained", ob_cnt, 0);
        chk(ib_cnt == 3, "R5 inbound stops at full", ib_cnt, 3);
        for (int k = 0; k < 3; k++)
            chk(ib_mem[k] == W'(8'hA0 + k), "R5 inbound order", ib_mem[k], 8'hA0 + k);
        chk(!ob_rd, "R8 empty stops reads", ob_rd, 0);

        // hidden loopback: port word must stay put
        cs_n = 1'b1; en = 1'b0;
        ob_mem[5] = 8'h31; ob_mem[6] = 8'h32;
        ob_cnt = 2; ib_cnt = 0; ib_cap = 8;
        dir = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ib_cnt == 2, "R4 hidden transfer count", ib_cnt, 2);
        chk(ib_mem[0] == 8'h31 && ib_mem[1] == 8'h32, "R4 hidden data",
            ib_mem[1], 8'h32);
        chk(port_dout == 8'hA4, "R9 hidden keeps port", port_dout, 8'hA4);
        chk(!port_oe, "R4/R7 hidden not driven", port_oe, 0);
        cs_n = 1'b1;
        summary();
    end

endmodule